// File: doc/BRIEF.md
# Keypad Controller Command Register Interface

This block is the command layer of a keypad and general-purpose I/O controller that sits behind a serial slave port. The port logic, which is not part of this block, presents start events, written bytes and read requests. The first byte written after a write start picks a command. Later written bytes are parameters for that command, and read requests return bytes for the command picked last. Each transaction keeps a byte counter, so a command can take several parameter bytes or return several data bytes.

The block holds the configuration, interrupt status, sticky error flags, active time, debounce time, keypad geometry and clock setting, as well as three 16-bit I/O words for pull selection, direction and output state. It checks every parameter and latches error flags. A small key event queue is filled from the scan logic and drained through read commands. The interrupt line is active low. PWM script loads, starts and stops are not run here: they are passed on as one-cycle pulses to a separate engine, and that engine's end flags come back into the status register.

Top module: `kpd_cmd_regs`

## Requirements
- R1: After `rst_n` goes low, config is 0x80, active time 125, debounce 3, keypad size 0x33, clock 0x08, all three I/O words 0x0000, error 0x00, and status holds only the not-initialised flag (bit 4, value 0x10).
- R2: `irq_n` is low whenever any status bit is set and high when status is 0x00.
- R3: Reading 0x82 returns status in data byte 0 and 0x00 in later bytes. The read clears status only when bit 4 is clear. While bit 4 is set, status is left unchanged.
- R4: Command 0x83 with parameter 0xAA restores config, active time, debounce, keypad size, clock and status to the R1 values and leaves the error flags unchanged. Any other parameter sets bad-parameter (error bit 0).
- R5: Writes to 0x84 (pull), 0x85 (direction) and 0x86 (output state) take a low byte, which also zeroes the high half, and then a high byte, which completes the command. Reads of 0x87 (direction) and 0x88 (output state) return the low byte, then the high byte, then 0x00.
- R6: 0x90 stores the keypad size even when it is invalid. It sets bad-parameter when bits 3:0 are outside 3..12 or bits 7:4 are outside 3..8. 0x91 reads the stored size.
- R7: 0x8F stores debounce and sets bad-parameter for 0x00. 0x93 stores the clock and sets bad-parameter when bits 1:0 are 01 or 10. 0x8B stores the active time without any check.
- R8: 0x80 returns 0x00 and then 0x04, and 0x00 after that. 0x94 returns the clock with bits 1:0 forced to 10. 0x92 returns config bits 3:0 with the upper nibble zero. 0x8C returns the error flags. 0x8E returns 0x00.
- R9: A one-byte write to 0x81 stores config, clears status and empties the key queue.
- R10: An unrecognised command code, on a write parameter or on a read, sets unknown-command (error bit 1). A read of it returns 0x00.
- R11: When a write command completes, the selected command becomes the reserved code 0xFF. A further parameter byte then sets bad-parameter, and a read then counts as an unknown command.
- R12: 0x96 (start) and the first byte of 0x95 (script load) are bad parameters when bits 1:0 are zero or bits 7:2 exceed 59. 0x97 (stop) is a bad parameter when bits 1:0 are zero. A valid start or stop pulses its output for one cycle with the channel, and the start also gives the address. A valid 3-byte load pulses `pwm_load` with the word formed from the high byte followed by the low byte.
- R13: A key event stores {key_down, key_code} and sets status bit 0. On a full queue it sets FIFO-overflow (error bit 6) instead. It is dropped with no effect while both status bit 3 and error bit 6 are set. 0x89 pops the oldest entry, or returns 0x00 when the queue is empty. 0x8A returns the entry at the offset given by the read byte number without removing it, or 0x00 past the end.
- R14: Error flags only accumulate until `rst_n`. Setting any of them sets status bit 3 in the same cycle. A pulse on `pwm_end[n]` sets status bit 5+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Start of a transaction; resets the byte counter |
| txn_write | input | 1 | Direction of the starting transaction: 1 write, 0 read |
| wr_valid | input | 1 | Written byte is present |
| wr_byte | input | 8 | Written byte (command or parameter) |
| rd_req | input | 1 | Host requests one read byte |
| rd_byte | output | 8 | Read data, valid the cycle after rd_req |
| rd_ack | output | 1 | Marks rd_byte as fresh |
| key_valid | input | 1 | Key event from the scan logic |
| key_code | input | 7 | Key identifier |
| key_down | input | 1 | 1 for press, 0 for release |
| pwm_end | input | 3 | End-of-script pulses, one per PWM channel |
| irq_n | output | 1 | Active-low interrupt |
| cfg_word | output | 8 | Stored configuration |
| act_time | output | 8 | Active time setting |
| debounce | output | 8 | Debounce setting |
| key_size | output | 8 | Keypad geometry setting |
| clk_word | output | 8 | Clock setting |
| gpio_pull | output | 16 | Pull selection word |
| gpio_dir | output | 16 | Direction word |
| gpio_out | output | 16 | Output state word |
| pwm_load | output | 1 | Script word load pulse |
| pwm_start | output | 1 | Channel start pulse |
| pwm_stop | output | 1 | Channel stop pulse |
| pwm_chan | output | 2 | Channel of the pulse (1..3) |
| pwm_addr | output | 6 | Script address of the pulse |
| pwm_word | output | 16 | Script word for pwm_load |

## Verification
The hardest case to reach is the key-event drop rule. It needs a completely full queue, then one more event to raise the overflow flag, with the status error bit still set when the next event arrives. That means no status read may fall in between, and the error flags can only be cleared by `rst_n`. The directed stimulus fills the queue with sixteen distinct codes, overflows it, drains it with pop reads, and then offers one more key. An empty pop proves that key was discarded. The parameter checks are stressed by seeded random values for the four single-byte setting commands. A hardware reset comes before each write, so that the sticky error byte reflects that one write alone.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    // command codes (wire protocol, fixed by the host software)
    localparam logic [7:0] CMD_ID_RD    = 8'h80;
    localparam logic [7:0] CMD_CFG_WR   = 8'h81;
    localparam logic [7:0] CMD_ST_RD    = 8'h82;
    localparam logic [7:0] CMD_SOFT_RST = 8'h83;
    localparam logic [7:0] CMD_PULL_WR  = 8'h84;
    localparam logic [7:0] CMD_DIR_WR   = 8'h85;
    localparam logic [7:0] CMD_OUT_WR   = 8'h86;
    localparam logic [7:0] CMD_DIR_RD   = 8'h87;
    localparam logic [7:0] CMD_OUT_RD   = 8'h88;
    localparam logic [7:0] CMD_Q_POP    = 8'h89;
    localparam logic [7:0] CMD_Q_PEEK   = 8'h8A;
    localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
    localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
    localparam logic [7:0] CMD_ROT_RD   = 8'h8E;
    localparam logic [7:0] CMD_DBN_WR   = 8'h8F;
    localparam logic [7:0] CMD_SIZE_WR  = 8'h90;
    localparam logic [7:0] CMD_SIZE_RD  = 8'h91;
    localparam logic [7:0] CMD_CFG_RD   = 8'h92;
    localparam logic [7:0] CMD_CLK_WR   = 8'h93;
    localparam logic [7:0] CMD_CLK_RD   = 8'h94;
    localparam logic [7:0] CMD_PWM_LD   = 8'h95;
    localparam logic [7:0] CMD_PWM_GO   = 8'h96;
    localparam logic [7:0] CMD_PWM_HALT = 8'h97;
    localparam logic [7:0] CMD_DONE     = 8'hFF;

    // status and error bit positions
    localparam int ST_KEY    = 0;
    localparam int ST_ERR    = 3;
    localparam int ST_NOINIT = 4;
    localparam int ST_PWM0   = 5;
    localparam int ER_PARAM  = 0;
    localparam int ER_UNK    = 1;
    localparam int ER_FIFO   = 6;

    // reset values
    localparam logic [7:0] DEF_CFG    = 8'h80;
    localparam logic [7:0] DEF_STATUS = 8'h10;
    localparam logic [7:0] DEF_ACT    = 8'd125;
    localparam logic [7:0] DEF_DBN    = 8'd3;
    localparam logic [7:0] DEF_SIZE   = 8'h33;
    localparam logic [7:0] DEF_CLK    = 8'h08;
    localparam logic [7:0] SOFT_KEY   = 8'hAA;
    localparam logic [7:0] ID_LO      = 8'h00;
    localparam logic [7:0] ID_HI      = 8'h04;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] cnt;
        logic       wr;
    } kpd_seq_t;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [7:0]  status;
        logic [7:0]  err;
        logic [7:0]  act;
        logic [7:0]  dbn;
        logic [7:0]  size;
        logic [7:0]  clk;
        logic [15:0] pull;
        logic [15:0] dir;
        logic [15:0] outv;
        logic [7:0]  faddr;
        logic [15:0] fword;
        logic [7:0]  rd_data;
        logic        rd_ack;
        logic        pwm_ld;
        logic        pwm_go;
        logic        pwm_halt;
        logic [1:0]  pwm_chan;
        logic [5:0]  pwm_addr;
    } kpd_regs_t;

endpackage

// File: rtl/kpd_seq.sv
module kpd_seq
    import kpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start_i,
    input  logic       txn_write_i,
    input  logic       wr_valid_i,
    input  logic [7:0] wr_byte_i,
    input  logic       rd_req_i,
    input  logic       done_i,
    output logic [7:0] cmd_o,
    output logic [7:0] idx_o,
    output logic       prm_valid_o,
    output logic       rd_valid_o
);

    localparam logic [7:0] CNT_SAT = 8'hFF;

    kpd_seq_t seq_d, seq_q;

    assign cmd_o       = seq_q.cmd;
    assign idx_o       = seq_q.wr ? (seq_q.cnt - 8'd1) : seq_q.cnt;
    assign prm_valid_o = !txn_start_i && wr_valid_i && seq_q.wr && (seq_q.cnt != 8'd0);
    assign rd_valid_o  = !txn_start_i && rd_req_i && !seq_q.wr;

    always_comb begin
        seq_d = seq_q;
        if (txn_start_i) begin
            seq_d.cnt = 8'd0;
            seq_d.wr  = txn_write_i;
        end else if (wr_valid_i && seq_q.wr) begin
            if (seq_q.cnt == 8'd0) begin
                seq_d.cmd = wr_byte_i;
            end else if (done_i) begin
                seq_d.cmd = CMD_DONE;
            end
            if (seq_q.cnt != CNT_SAT) begin
                seq_d.cnt = seq_q.cnt + 8'd1;
            end
        end else if (rd_req_i && !seq_q.wr) begin
            if (seq_q.cnt != CNT_SAT) begin
                seq_d.cnt = seq_q.cnt + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{cmd: CMD_DONE, cnt: 8'd0, wr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_CMD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (seq_q.cmd == CMD_DONE)); // R11

endmodule

// File: rtl/kpd_key_fifo.sv
module kpd_key_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [7:0]            data_i,
    input  logic                  pop_i,
    input  logic                  flush_i,
    input  logic [7:0]            peek_off_i,
    output logic [$clog2(DEPTH):0] cnt_o,
    output logic                  full_o,
    output logic [7:0]            head_o,
    output logic [7:0]            peek_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam int SW = (CW > 8) ? CW + 1 : 9;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         rp;
        logic [AW-1:0]         wp;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    logic [SW-1:0] peek_sum;
    logic [SW-1:0] peek_idx;

    assign cnt_o  = f_q.cnt;
    assign full_o = (32'(f_q.cnt) == DEPTH);
    assign head_o = f_q.mem[f_q.rp];

    always_comb begin
        peek_sum = SW'(f_q.rp) + SW'(peek_off_i);
        peek_idx = (32'(peek_sum) >= DEPTH) ? peek_sum - SW'(DEPTH) : peek_sum;
        if (SW'(peek_off_i) < SW'(f_q.cnt)) begin
            peek_o = f_q.mem[peek_idx[AW-1:0]];
        end else begin
            peek_o = 8'h00;
        end
    end

    always_comb begin
        f_d = f_q;
        if (flush_i) begin
            f_d.rp  = '0;
            f_d.wp  = '0;
            f_d.cnt = '0;
        end else begin
            if (pop_i && f_q.cnt != '0) begin
                f_d.rp = bump(f_q.rp);
            end
            if (push_i && !full_o) begin
                f_d.mem[f_q.wp] = data_i;
                f_d.wp          = bump(f_q.wp);
            end
            f_d.cnt = f_q.cnt + CW'(push_i && !full_o) - CW'(pop_i && f_q.cnt != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(f_q.cnt) <= DEPTH); // R13
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> !full_o); // R13

endmodule

// File: rtl/kpd_regs.sv
module kpd_regs
    import kpd_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int ROW_MIN      = 3,
    parameter int ROW_MAX      = 12,
    parameter int COL_MIN      = 3,
    parameter int COL_MAX      = 8,
    parameter int PWM_ADDR_MAX = 59
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  cmd_i,
    input  logic [7:0]                  idx_i,
    input  logic                        prm_valid_i,
    input  logic [7:0]                  prm_byte_i,
    input  logic                        rd_valid_i,
    input  logic                        key_valid_i,
    input  logic [7:0]                  key_byte_i,
    input  logic [2:0]                  pwm_end_i,
    input  logic [$clog2(FIFO_DEPTH):0] fifo_cnt_i,
    input  logic                        fifo_full_i,
    input  logic [7:0]                  fifo_head_i,
    input  logic [7:0]                  fifo_peek_i,
    output logic                        done_o,
    output logic                        fifo_push_o,
    output logic                        fifo_pop_o,
    output logic                        fifo_flush_o,
    output kpd_regs_t                   regs_o,
    output logic                        irq_n_o
);

    localparam kpd_regs_t RESET_VAL = '{
        cfg: DEF_CFG, status: DEF_STATUS, act: DEF_ACT, dbn: DEF_DBN,
        size: DEF_SIZE, clk: DEF_CLK, default: '0};

    kpd_regs_t r_d, r_q;

    logic [7:0] set_err;
    logic       clr_st;
    logic       soft_rst;
    logic       key_drop;
    logic       key_set;
    logic [7:0] v;

    function automatic logic size_bad(input logic [7:0] s);
        return (int'(s[3:0]) < ROW_MIN) || (int'(s[3:0]) > ROW_MAX) ||
               (int'(s[7:4]) < COL_MIN) || (int'(s[7:4]) > COL_MAX);
    endfunction

    function automatic logic pwm_bad(input logic [7:0] s);
        return (s[1:0] == 2'b00) || (int'(s[7:2]) > PWM_ADDR_MAX);
    endfunction

    function automatic logic [7:0] pick16(input logic [15:0] w, input logic [7:0] i);
        return (i == 8'd0) ? w[7:0] : (i == 8'd1) ? w[15:8] : 8'h00;
    endfunction

    assign v        = prm_byte_i;
    assign regs_o   = r_q;
    assign irq_n_o  = (r_q.status == 8'h00);
    assign key_drop = r_q.status[ST_ERR] && r_q.err[ER_FIFO];

    // parameter bytes: one command step per byte
    always_comb begin
        r_d          = r_q;
        r_d.rd_ack   = 1'b0;
        r_d.pwm_ld   = 1'b0;
        r_d.pwm_go   = 1'b0;
        r_d.pwm_halt = 1'b0;
        set_err      = 8'h00;
        clr_st       = 1'b0;
        soft_rst     = 1'b0;
        done_o       = 1'b0;
        fifo_flush_o = 1'b0;
        fifo_pop_o   = 1'b0;
        fifo_push_o  = 1'b0;
        key_set      = 1'b0;

        if (prm_valid_i) begin
            case (cmd_i)
                CMD_CFG_WR: begin
                    r_d.cfg      = v;
                    clr_st       = 1'b1;
                    fifo_flush_o = 1'b1;
                    done_o       = 1'b1;
                end
                CMD_SOFT_RST: begin
                    done_o = 1'b1;
                    if (v == SOFT_KEY) soft_rst = 1'b1;
                    else               set_err[ER_PARAM] = 1'b1;
                end
                CMD_PULL_WR, CMD_DIR_WR, CMD_OUT_WR: begin
                    if (idx_i == 8'd0) begin
                        if (cmd_i == CMD_PULL_WR) r_d.pull = {8'h00, v};
                        if (cmd_i == CMD_DIR_WR)  r_d.dir  = {8'h00, v};
                        if (cmd_i == CMD_OUT_WR)  r_d.outv = {8'h00, v};
                    end else begin
                        if (cmd_i == CMD_PULL_WR) r_d.pull = r_q.pull | {v, 8'h00};
                        if (cmd_i == CMD_DIR_WR)  r_d.dir  = r_q.dir  | {v, 8'h00};
                        if (cmd_i == CMD_OUT_WR)  r_d.outv = r_q.outv | {v, 8'h00};
                        done_o = 1'b1;
                    end
                end
                CMD_ACT_WR: begin
                    r_d.act = v;
                    done_o  = 1'b1;
                end
                CMD_DBN_WR: begin
                    r_d.dbn = v;
                    done_o  = 1'b1;
                    if (v == 8'h00) set_err[ER_PARAM] = 1'b1;
                end
                CMD_SIZE_WR: begin
                    r_d.size = v;
                    done_o   = 1'b1;
                    if (size_bad(v)) set_err[ER_PARAM] = 1'b1;
                end
                CMD_CLK_WR: begin
                    r_d.clk = v;
                    done_o  = 1'b1;
                    if (v[1] ^ v[0]) set_err[ER_PARAM] = 1'b1;
                end
                CMD_PWM_LD: begin
                    if (idx_i == 8'd0) begin
                        if (pwm_bad(v)) begin
                            set_err[ER_PARAM] = 1'b1;
                            done_o            = 1'b1;
                        end else begin
                            r_d.faddr = v;
                            r_d.fword = 16'h0000;
                        end
                    end else if (idx_i == 8'd1) begin
                        r_d.fword = r_q.fword | {v, 8'h00};
                    end else begin
                        r_d.fword    = r_q.fword | {8'h00, v};
                        r_d.pwm_ld   = 1'b1;
                        r_d.pwm_chan = r_q.faddr[1:0];
                        r_d.pwm_addr = r_q.faddr[7:2];
                        done_o       = 1'b1;
                    end
                end
                CMD_PWM_GO: begin
                    done_o = 1'b1;
                    if (pwm_bad(v)) begin
                        set_err[ER_PARAM] = 1'b1;
                    end else begin
                        r_d.pwm_go   = 1'b1;
                        r_d.pwm_chan = v[1:0];
                        r_d.pwm_addr = v[7:2];
                    end
                end
                CMD_PWM_HALT: begin
                    done_o = 1'b1;
                    if (v[1:0] == 2'b00) begin
                        set_err[ER_PARAM] = 1'b1;
                    end else begin
                        r_d.pwm_halt = 1'b1;
                        r_d.pwm_chan = v[1:0];
                    end
                end
                CMD_DONE: set_err[ER_PARAM] = 1'b1;
                default:  set_err[ER_UNK]   = 1'b1;
            endcase
        end

        // read bytes
        if (rd_valid_i) begin
            r_d.rd_ack = 1'b1;
            case (cmd_i)
                CMD_ID_RD:   r_d.rd_data = (idx_i == 8'd0) ? ID_LO : (idx_i == 8'd1) ? ID_HI : 8'h00;
                CMD_ST_RD: begin
                    r_d.rd_data = (idx_i == 8'd0) ? r_q.status : 8'h00;
                    clr_st      = !r_q.status[ST_NOINIT];
                end
                CMD_DIR_RD:  r_d.rd_data = pick16(r_q.dir, idx_i);
                CMD_OUT_RD:  r_d.rd_data = pick16(r_q.outv, idx_i);
                CMD_ERR_RD:  r_d.rd_data = r_q.err;
                CMD_ROT_RD:  r_d.rd_data = 8'h00;
                CMD_SIZE_RD: r_d.rd_data = r_q.size;
                CMD_CFG_RD:  r_d.rd_data = {4'h0, r_q.cfg[3:0]};
                CMD_CLK_RD:  r_d.rd_data = {r_q.clk[7:2], 2'b10};
                CMD_Q_POP: begin
                    if (fifo_cnt_i != '0) begin
                        r_d.rd_data = fifo_head_i;
                        fifo_pop_o  = 1'b1;
                    end else begin
                        r_d.rd_data = 8'h00;
                    end
                end
                CMD_Q_PEEK:  r_d.rd_data = fifo_peek_i;
                default: begin
                    r_d.rd_data     = 8'h00;
                    set_err[ER_UNK] = 1'b1;
                end
            endcase
        end

        // key events from the scan side
        if (key_valid_i && !key_drop) begin
            if (fifo_full_i) begin
                set_err[ER_FIFO] = 1'b1;
            end else if (!fifo_flush_o) begin
                fifo_push_o = 1'b1;
                key_set     = 1'b1;
            end
        end

        // soft reset restores the setting registers
        if (soft_rst) begin
            r_d.cfg  = DEF_CFG;
            r_d.act  = DEF_ACT;
            r_d.dbn  = DEF_DBN;
            r_d.size = DEF_SIZE;
            r_d.clk  = DEF_CLK;
        end

        // status merge: base, then sources of new flags
        if (soft_rst)    r_d.status = DEF_STATUS;
        else if (clr_st) r_d.status = 8'h00;
        else             r_d.status = r_q.status;
        r_d.status[ST_PWM0 +: 3] = r_d.status[ST_PWM0 +: 3] | pwm_end_i;
        if (key_set)          r_d.status[ST_KEY] = 1'b1;
        if (set_err != 8'h00) r_d.status[ST_ERR] = 1'b1;
        r_d.err = r_q.err | set_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err & $past(r_q.err)) == $past(r_q.err)); // R14
    AST_ERR_RAISES_ST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err != $past(r_q.err)) |-> r_q.status[ST_ERR]); // R14
    AST_NOINIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && cmd_i == CMD_ST_RD && r_q.status[ST_NOINIT]) |=> r_q.status[ST_NOINIT]); // R3
    AST_PWM_CHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pwm_go || r_q.pwm_halt || r_q.pwm_ld) |-> (r_q.pwm_chan != 2'b00)); // R12
    AST_ONE_PWM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.pwm_go, r_q.pwm_halt, r_q.pwm_ld})); // R12

endmodule

// File: rtl/kpd_cmd_regs.sv
module kpd_cmd_regs
    import kpd_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int ROW_MIN      = 3,
    parameter int ROW_MAX      = 12,
    parameter int COL_MIN      = 3,
    parameter int COL_MAX      = 8,
    parameter int PWM_ADDR_MAX = 59
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_start,
    input  logic        txn_write,
    input  logic        wr_valid,
    input  logic [7:0]  wr_byte,
    input  logic        rd_req,
    output logic [7:0]  rd_byte,
    output logic        rd_ack,
    input  logic        key_valid,
    input  logic [6:0]  key_code,
    input  logic        key_down,
    input  logic [2:0]  pwm_end,
    output logic        irq_n,
    output logic [7:0]  cfg_word,
    output logic [7:0]  act_time,
    output logic [7:0]  debounce,
    output logic [7:0]  key_size,
    output logic [7:0]  clk_word,
    output logic [15:0] gpio_pull,
    output logic [15:0] gpio_dir,
    output logic [15:0] gpio_out,
    output logic        pwm_load,
    output logic        pwm_start,
    output logic        pwm_stop,
    output logic [1:0]  pwm_chan,
    output logic [5:0]  pwm_addr,
    output logic [15:0] pwm_word
);

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic [7:0]  cmd, idx;
    logic        prm_valid, rd_valid, done;
    logic        f_push, f_pop, f_flush, f_full;
    logic [CW-1:0] f_cnt;
    logic [7:0]  f_head, f_peek;
    kpd_regs_t   regs;

    kpd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start_i (txn_start),
        .txn_write_i (txn_write),
        .wr_valid_i  (wr_valid),
        .wr_byte_i   (wr_byte),
        .rd_req_i    (rd_req),
        .done_i      (done),
        .cmd_o       (cmd),
        .idx_o       (idx),
        .prm_valid_o (prm_valid),
        .rd_valid_o  (rd_valid)
    );

    kpd_key_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (f_push),
        .data_i     ({key_down, key_code}),
        .pop_i      (f_pop),
        .flush_i    (f_flush),
        .peek_off_i (idx),
        .cnt_o      (f_cnt),
        .full_o     (f_full),
        .head_o     (f_head),
        .peek_o     (f_peek)
    );

    kpd_regs #(
        .FIFO_DEPTH   (FIFO_DEPTH),
        .ROW_MIN      (ROW_MIN),
        .ROW_MAX      (ROW_MAX),
        .COL_MIN      (COL_MIN),
        .COL_MAX      (COL_MAX),
        .PWM_ADDR_MAX (PWM_ADDR_MAX)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .idx_i        (idx),
        .prm_valid_i  (prm_valid),
        .prm_byte_i   (wr_byte),
        .rd_valid_i   (rd_valid),
        .key_valid_i  (key_valid),
        .key_byte_i   ({key_down, key_code}),
        .pwm_end_i    (pwm_end),
        .fifo_cnt_i   (f_cnt),
        .fifo_full_i  (f_full),
        .fifo_head_i  (f_head),
        .fifo_peek_i  (f_peek),
        .done_o       (done),
        .fifo_push_o  (f_push),
        .fifo_pop_o   (f_pop),
        .fifo_flush_o (f_flush),
        .regs_o       (regs),
        .irq_n_o      (irq_n)
    );

    assign rd_byte   = regs.rd_data;
    assign rd_ack    = regs.rd_ack;
    assign cfg_word  = regs.cfg;
    assign act_time  = regs.act;
    assign debounce  = regs.dbn;
    assign key_size  = regs.size;
    assign clk_word  = regs.clk;
    assign gpio_pull = regs.pull;
    assign gpio_dir  = regs.dir;
    assign gpio_out  = regs.outv;
    assign pwm_load  = regs.pwm_ld;
    assign pwm_start = regs.pwm_go;
    assign pwm_stop  = regs.pwm_halt;
    assign pwm_chan  = regs.pwm_chan;
    assign pwm_addr  = regs.pwm_addr;
    assign pwm_word  = regs.fword;

    AST_IRQ_FOLLOWS_ST: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.status != 8'h00) |-> !irq_n); // R2

endmodule

// File: tb/kpd_cmd_regs_bench.sv
`timescale 1ns/1ps
module kpd_cmd_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0, txn_write = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_byte;
    logic        rd_ack;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = 7'h00;
    logic        key_down = 1'b0;
    logic [2:0]  pwm_end = 3'b000;
    logic        irq_n;
    logic [7:0]  cfg_word, act_time, debounce, key_size, clk_word;
    logic [15:0] gpio_pull, gpio_dir, gpio_out, pwm_word;
    logic        pwm_load, pwm_start, pwm_stop;
    logic [1:0]  pwm_chan;
    logic [5:0]  pwm_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    kpd_cmd_regs u_kpd_cmd_regs (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic f_size_bad(input logic [7:0] s);
        return (s[3:0] < 4'd3) || (s[3:0] > 4'd12) || (s[7:4] < 4'd3) || (s[7:4] > 4'd8);
    endfunction
    function automatic logic f_clk_bad(input logic [7:0] s);
        return (s[1:0] == 2'b01) || (s[1:0] == 2'b10);
    endfunction
    function automatic logic [7:0] f_clk_rd(input logic [7:0] s);
        return {s[7:2], 2'b10};
    endfunction

    task automatic hw_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask
    task automatic t_start(input logic w);
        @(negedge clk); txn_start = 1'b1; txn_write = w;
        @(negedge clk); txn_start = 1'b0;
    endtask
    task automatic t_put(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_byte = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask
    task automatic t_get(output logic [7:0] b);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; b = rd_byte;
    endtask
    task automatic wr1(input logic [7:0] c, input logic [7:0] a);
        t_start(1'b1); t_put(c); t_put(a);
    endtask
    task automatic wr2(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
        t_start(1'b1); t_put(c); t_put(a); t_put(b);
    endtask
    task automatic sel_rd(input logic [7:0] c);
        t_start(1'b1); t_put(c); t_start(1'b0);
    endtask
    task automatic rd1(input logic [7:0] c, output logic [7:0] b);
        sel_rd(c); t_get(b);
    endtask
    task automatic key(input logic [6:0] k, input logic d);
        @(negedge clk); key_valid = 1'b1; key_code = k; key_down = d;
        @(negedge clk); key_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] b, b2, b3, c, v;
        logic       exp_bad;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 reset state
        chk("R1 cfg", cfg_word, 8'h80);
        chk("R1 act", act_time, 8'd125);
        chk("R1 dbn", debounce, 8'd3);
        chk("R1 size", key_size, 8'h33);
        chk("R1 clk", clk_word, 8'h08);
        chk("R1 gpio", {gpio_pull, gpio_dir, gpio_out}, 48'h0);
        chk("R2 irq low at noinit", irq_n, 1'b0);
        rd1(8'h8C, b); chk("R1 err", b, 8'h00);

        // R3 status read keeps noinit
        rd1(8'h82, b); chk("R3 status", b, 8'h10);
        t_get(b2);     chk("R3 status byte1", b2, 8'h00);
        rd1(8'h82, b); chk("R3 noinit kept", b, 8'h10);

        // R9 / R8 config
        wr1(8'h81, 8'hA7);
        chk("R9 status cleared irq", irq_n, 1'b1);
        chk("R9 cfg stored", cfg_word, 8'hA7);
        rd1(8'h92, b); chk("R8 cfg low nibble", b, 8'h07);
        sel_rd(8'h80); t_get(b); t_get(b2); t_get(b3);
        chk("R8 id lo", b, 8'h00); chk("R8 id hi", b2, 8'h04); chk("R8 id tail", b3, 8'h00);
        rd1(8'h94, b); chk("R8 clk read", b, 8'h0A);
        rd1(8'h8E, b); chk("R8 rotator", b, 8'h00);

        // R5 I/O words
        wr2(8'h85, 8'h34, 8'h12); chk("R5 dir", gpio_dir, 16'h1234);
        t_start(1'b1); t_put(8'h86); t_put(8'hCD);
        chk("R5 out low only", gpio_out, 16'h00CD);
        t_put(8'hAB); chk("R5 out full", gpio_out, 16'hABCD);
        wr2(8'h84, 8'h0F, 8'hF0); chk("R5 pull", gpio_pull, 16'hF00F);
        wr2(8'h85, 8'h01, 8'h00); chk("R5 low write zeroes high", gpio_dir, 16'h0001);
        sel_rd(8'h88); t_get(b); t_get(b2); t_get(b3);
        chk("R5 rd lo", b, 8'hCD); chk("R5 rd hi", b2, 8'hAB); chk("R5 rd tail", b3, 8'h00);
        rd1(8'h8C, b); chk("R5 no error", b, 8'h00);
        chk("R2 irq high idle", irq_n, 1'b1);

        // R11 extra parameter after completion
        t_start(1'b1); t_put(8'h8B); t_put(8'h44); t_put(8'h99);
        chk("R11 act stored", act_time, 8'h44);
        rd1(8'h8C, b); chk("R11 extra byte bad param", b, 8'h01);
        chk("R14 irq after error", irq_n, 1'b0);
        rd1(8'h82, b); chk("R14 status err bit", b, 8'h08);
        chk("R3 status cleared", irq_n, 1'b1);
        // R11 read after completion -> unknown
        wr1(8'h8B, 8'h45); t_start(1'b0); t_get(b);
        chk("R11 read retired cmd", b, 8'h00);
        rd1(8'h8C, b); chk("R10 unknown from retired", b, 8'h03);

        // R10 unknown write and read
        hw_reset();
        wr1(8'h8D, 8'h00);
        rd1(8'h8C, b); chk("R10 unknown write", b, 8'h02);
        hw_reset();
        rd1(8'h99, b); chk("R10 unknown read data", b, 8'h00);
        rd1(8'h8C, b); chk("R10 unknown read flag", b, 8'h02);

        // R4 soft reset
        hw_reset();
        wr1(8'h81, 8'h00); wr1(8'h8B, 8'h11); wr1(8'h93, 8'hF3);
        wr1(8'h83, 8'h55);
        rd1(8'h8C, b); chk("R4 wrong key bad param", b, 8'h01);
        chk("R4 wrong key no reset", act_time, 8'h11);
        wr1(8'h83, 8'hAA);
        chk("R4 act restored", act_time, 8'd125);
        chk("R4 clk restored", clk_word, 8'h08);
        chk("R4 cfg restored", cfg_word, 8'h80);
        rd1(8'h82, b); chk("R4 status noinit", b, 8'h10);
        rd1(8'h8C, b); chk("R4 error kept", b, 8'h01);

        // R12 PWM
        hw_reset();
        t_start(1'b1); t_put(8'h96); t_put({6'd10, 2'd2});
        chk("R12 start pulse", {pwm_start, pwm_chan, pwm_addr}, {1'b1, 2'd2, 6'd10});
        @(negedge clk); chk("R12 start one cycle", pwm_start, 1'b0);
        t_start(1'b1); t_put(8'h95); t_put({6'd5, 2'd3}); t_put(8'hAB); t_put(8'hCD);
        chk("R12 load pulse", {pwm_load, pwm_chan, pwm_addr, pwm_word}, {1'b1, 2'd3, 6'd5, 16'hABCD});
        t_start(1'b1); t_put(8'h97); t_put(8'h01);
        chk("R12 stop pulse", {pwm_stop, pwm_chan}, {1'b1, 2'd1});
        rd1(8'h8C, b); chk("R12 valid no error", b, 8'h00);
        wr1(8'h96, {6'd60, 2'd1}); chk("R12 bad addr no pulse", pwm_start, 1'b0);
        rd1(8'h8C, b); chk("R12 bad addr", b, 8'h01);
        hw_reset(); wr1(8'h97, 8'hFC);
        rd1(8'h8C, b); chk("R12 stop chan zero", b, 8'h01);
        hw_reset(); wr1(8'h95, 8'h00);
        rd1(8'h8C, b); chk("R12 load chan zero", b, 8'h01);

        // R14 pwm end flags
        hw_reset(); wr1(8'h81, 8'h00);
        @(negedge clk); pwm_end = 3'b010; @(negedge clk); pwm_end = 3'b000;
        chk("R14 irq on pwm end", irq_n, 1'b0);
        rd1(8'h82, b); chk("R14 pwm end bit", b, 8'h40);

        // R13 key queue
        hw_reset(); wr1(8'h81, 8'h00);
        rd1(8'h89, b); chk("R13 pop empty", b, 8'h00);
        for (int i = 0; i < 16; i++) key(7'(i + 3), i[0]);
        chk("R13 key irq", irq_n, 1'b0);
        key(7'h70, 1'b1);
        rd1(8'h8C, b); chk("R13 overflow flag", b, 8'h40);
        sel_rd(8'h8A);
        for (int i = 0; i < 17; i++) begin
            t_get(b);
            chk("R13 peek", b, (i < 16) ? {i[0], 7'(i + 3)} : 8'h00);
        end
        sel_rd(8'h89);
        for (int i = 0; i < 17; i++) begin
            t_get(b);
            chk("R13 pop", b, (i < 16) ? {i[0], 7'(i + 3)} : 8'h00);
        end
        key(7'h22, 1'b1);
        rd1(8'h89, b); chk("R13 key dropped after overflow", b, 8'h00);
        rd1(8'h82, b); chk("R13 status key and err", b, 8'h09);
        key(7'h23, 1'b0);
        rd1(8'h89, b); chk("R13 key accepted after status read", b, 8'h23);
        key(7'h24, 1'b1); key(7'h25, 1'b1);
        wr1(8'h81, 8'h00);
        rd1(8'h89, b); chk("R9 queue emptied", b, 8'h00);

        // R6 / R7 random settings against bench model
        for (int it = 0; it < 300; it++) begin
            hw_reset();
            case ($urandom % 4)
                0: c = 8'h8B;
                1: c = 8'h8F;
                2: c = 8'h90;
                default: c = 8'h93;
            endcase
            v = 8'($urandom);
            if (c == 8'h8F && ($urandom % 4) == 0) v = 8'h00;
            wr1(c, v);
            case (c)
                8'h8B: begin exp_bad = 1'b0;           chk("R7 act", act_time, v); end
                8'h8F: begin exp_bad = (v == 8'h00);   chk("R7 dbn", debounce, v); end
                8'h90: begin exp_bad = f_size_bad(v);  chk("R6 size stored", key_size, v);
                             rd1(8'h91, b);             chk("R6 size read", b, v); end
                default: begin exp_bad = f_clk_bad(v); chk("R7 clk stored", clk_word, v);
                             rd1(8'h94, b);             chk("R8 clk read", b, f_clk_rd(v)); end
            endcase
            rd1(8'h8C, b);
            chk((c == 8'h90) ? "R6 check" : "R7 check", b, {7'h0, exp_bad});
            rd1(8'h82, b);
            chk("R14 status err", b, exp_bad ? 8'h18 : 8'h10);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule